// File: doc/BRIEF.md
# Right-Justified Oversampled Audio Word Receiver

This block sits behind an external interpolation filter and turns its serial output back into parallel samples. The filter supplies a bit clock, a word clock running at four or eight times the audio sample rate, and right-justified data. The data arrives either on one shared line that carries left and right words in turn, or on two lines that each carry one channel. The block rebuilds each word, sign-extends it to 32 bits and presents it on a left or right output with a one-cycle valid strobe. A lock flag reports whether the word-clock periods are steady and long enough for the chosen word length.

All serial inputs are sampled by the block's own system clock. That clock has to run several times faster than the bit clock. A small configuration port sets the word length and the line mode, and it can also take the receiver out of service. The receiver works only while the bypass path is selected, meaning the one-bit stream select is clear and the pass-through enable is set. At any other setting the receiver is held idle and cleared.

Top module: `rj_audio_rx`

## Requirements
- R1: The word-length code takes three values: 3'b000 for 16 bits, 3'b001 for 32 bits and 3'b010 for 24 bits. 3'b010 (24 bits) is in force after reset until a legal code is written.
- R2: A configuration write whose word-length code is 3'b011 to 3'b111 leaves the stored word length unchanged. The other fields of the same write still take effect.
- R3: The receiver is active only while `cfg_dsd_sel` is 0 and `cfg_thru` is 1. While it is inactive, no valid strobe and no lock are produced, and any partly received state is discarded.
- R4: A data bit is taken at each rising edge of `bck`. At a word boundary, the delivered word is the last N bits taken, where N is the word length, received MSB first, so the LSB is the bit just before the word-clock edge. Bits taken earlier in the period have no effect.
- R5: 16-bit and 24-bit words are sign-extended from their top bit to 32 bits. 32-bit words are delivered unchanged.
- R6: In single-line mode (`cfg_dual` = 0), the words come from `sdata`. A falling edge of `wck` delivers the word received while `wck` was high on `word_l`. A rising edge delivers the word received while `wck` was low on `word_r`. The two strobes never assert together.
- R7: In dual-line mode (`cfg_dual` = 1), each falling edge of `wck` delivers the word from `sdata_l` on `word_l` and the word from `sdata_r` on `word_r`, both in the same cycle. `sdata` is ignored.
- R8: After the receiver becomes active, the first falling edge of `wck` only arms it and delivers nothing. Words are delivered from the next qualifying edge on.
- R9: Each valid strobe lasts exactly one clock cycle. An output word holds its value until its next strobe.
- R10: At each falling edge of `wck`, `locked` becomes 1 when two conditions hold: the number of `bck` rising edges since the previous falling edge equals the number in the period before it, and that number is at least 2N in single-line mode or N in dual-line mode. Otherwise `locked` becomes 0. It is 0 after reset and while the receiver is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_fmt | input | 3 | Word-length code (R1) |
| cfg_dual | input | 1 | 1 selects two per-channel data lines |
| cfg_dsd_sel | input | 1 | One-bit stream select; 1 holds the receiver idle |
| cfg_thru | input | 1 | Filter pass-through enable; 0 holds the receiver idle |
| bck | input | 1 | Serial bit clock |
| wck | input | 1 | Word clock at 4x or 8x the sample rate |
| sdata | input | 1 | Shared data line (single-line mode) |
| sdata_l | input | 1 | Left-channel data line (dual-line mode) |
| sdata_r | input | 1 | Right-channel data line (dual-line mode) |
| word_l | output | 32 | Last left word, sign-extended |
| word_r | output | 32 | Last right word, sign-extended |
| valid_l | output | 1 | One-cycle strobe for a new left word |
| valid_r | output | 1 | One-cycle strobe for a new right word |
| locked | output | 1 | Word-clock periods steady and long enough |

## Verification
The properties assume that `bck`, `wck` and the data lines change only away from `bck` rising edges. They also assume that each level of `bck` and `wck` is held for at least two system clocks, so that edges of the word clock never fall in neighbouring cycles and a strobe cannot repeat at once. The stimulus keeps within this. It holds each `bck` phase for two clocks and changes the word clock and data only together with the `bck` fall. Configuration is rewritten only while the bit clock is quiet and the receiver has been made inactive.

// File: rtl/rjrx_pkg.sv
package rjrx_pkg;

  localparam int unsigned WORD_MAX = 32;

  typedef enum logic [2:0] {
    FMT_16 = 3'b000,
    FMT_32 = 3'b001,
    FMT_24 = 3'b010
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic dual;
    logic dsd_sel;
    logic thru;
  } cfg_t;

  function automatic logic fmt_legal(input logic [2:0] code);
    return (code == 3'b000) || (code == 3'b001) || (code == 3'b010);
  endfunction

  function automatic int unsigned fmt_bits(input fmt_e f);
    case (f)
      FMT_16:  return 16;
      FMT_32:  return 32;
      default: return 24;
    endcase
  endfunction

  // Sign-extend the low bits of a captured shift register to the full word.
  function automatic logic [WORD_MAX-1:0] widen(input fmt_e f,
                                                input logic [WORD_MAX-1:0] raw);
    case (f)
      FMT_16:  return {{16{raw[15]}}, raw[15:0]};
      FMT_24:  return {{8{raw[23]}}, raw[23:0]};
      default: return raw;
    endcase
  endfunction

  // Minimum bit-clock count per word-clock period for lock.
  function automatic int unsigned lock_need(input fmt_e f, input logic dual);
    return dual ? fmt_bits(f) : 2 * fmt_bits(f);
  endfunction

endpackage

// File: rtl/rjrx_cfg.sv
module rjrx_cfg
  import rjrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] fmt_in,
  input  logic       dual_in,
  input  logic       dsd_in,
  input  logic       thru_in,
  output cfg_t       cfg,
  output logic       active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.fmt     <= FMT_24;
      cfg.dual    <= 1'b0;
      cfg.dsd_sel <= 1'b0;
      cfg.thru    <= 1'b0;
    end else if (wr) begin
      if (fmt_legal(fmt_in)) cfg.fmt <= fmt_e'(fmt_in);
      cfg.dual    <= dual_in;
      cfg.dsd_sel <= dsd_in;
      cfg.thru    <= thru_in;
    end
  end

  assign active = cfg.thru & ~cfg.dsd_sel;

endmodule

// File: rtl/rjrx_edge.sv
module rjrx_edge #(
  parameter int unsigned NSIG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] pin,
  output logic [NSIG-1:0] lvl,
  output logic [NSIG-1:0] chg
);

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= pin[g];
        s2 <= s1;
      end
    end
    assign lvl[g] = s1;
    assign chg[g] = s1 ^ s2;
  end

endmodule

// File: rtl/rjrx_lane.sv
module rjrx_lane #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         din,
  input  logic         shift_en,
  output logic [W-1:0] bits
);

  logic         d_q;
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= 1'b0;
      sr  <= '0;
    end else begin
      d_q <= din;
      if (clr)           sr <= '0;
      else if (shift_en) sr <= {sr[W-2:0], d_q};
    end
  end

  assign bits = sr;

endmodule

// File: rtl/rjrx_lock.sv
module rjrx_lock #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          mark,
  input  logic [CW-1:0] need,
  output logic          locked
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt, prev;
  logic          have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      prev      <= '0;
      have_prev <= 1'b0;
      locked    <= 1'b0;
    end else if (clr) begin
      cnt       <= '0;
      prev      <= '0;
      have_prev <= 1'b0;
      locked    <= 1'b0;
    end else if (mark) begin
      locked    <= have_prev && (cnt == prev) && (cnt >= need);
      prev      <= cnt;
      have_prev <= 1'b1;
      cnt       <= tick ? CW'(1) : '0;
    end else if (tick && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rj_audio_rx.sv
module rj_audio_rx
  import rjrx_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_fmt,
  input  logic        cfg_dual,
  input  logic        cfg_dsd_sel,
  input  logic        cfg_thru,
  input  logic        bck,
  input  logic        wck,
  input  logic        sdata,
  input  logic        sdata_l,
  input  logic        sdata_r,
  output logic [31:0] word_l,
  output logic [31:0] word_r,
  output logic        valid_l,
  output logic        valid_r,
  output logic        locked
);

  localparam int unsigned W     = WORD_MAX;
  localparam int unsigned LANES = 2;

  cfg_t cfg_q;
  logic active;

  rjrx_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .fmt_in  (cfg_fmt),
    .dual_in (cfg_dual),
    .dsd_in  (cfg_dsd_sel),
    .thru_in (cfg_thru),
    .cfg     (cfg_q),
    .active  (active)
  );

  // Named internal events, visible to the bound checker.
  logic [2:0] fmt_code;
  logic       dual_mode;
  assign fmt_code  = cfg_q.fmt;
  assign dual_mode = cfg_q.dual;

  logic [1:0] clk_lvl, clk_chg;

  rjrx_edge #(.NSIG(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   ({wck, bck}),
    .lvl   (clk_lvl),
    .chg   (clk_chg)
  );

  logic bck_rise, wck_rise, wck_fall;
  assign bck_rise = clk_lvl[0] & clk_chg[0];
  assign wck_rise = clk_lvl[1] & clk_chg[1];
  assign wck_fall = ~clk_lvl[1] & clk_chg[1];

  logic [LANES-1:0] lane_din;
  assign lane_din[0] = cfg_q.dual ? sdata_l : sdata;
  assign lane_din[1] = sdata_r;

  logic [W-1:0] lane_bits [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rjrx_lane #(.W(W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~active),
      .din      (lane_din[l]),
      .shift_en (bck_rise),
      .bits     (lane_bits[l])
    );
  end

  rjrx_lock #(.CW(CNT_W)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~active),
    .tick   (bck_rise),
    .mark   (wck_fall),
    .need   (CNT_W'(lock_need(cfg_q.fmt, cfg_q.dual))),
    .locked (locked)
  );

  logic armed;
  logic take_l, take_r;
  assign take_l = active & armed & wck_fall;
  assign take_r = active & armed & (cfg_q.dual ? wck_fall : wck_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (!active) begin
      armed <= 1'b0;
    end else if (wck_fall) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_l  <= '0;
      word_r  <= '0;
      valid_l <= 1'b0;
      valid_r <= 1'b0;
    end else begin
      valid_l <= take_l;
      valid_r <= take_r;
      if (take_l) word_l <= widen(cfg_q.fmt, lane_bits[0]);
      if (take_r) word_r <= widen(cfg_q.fmt, cfg_q.dual ? lane_bits[1] : lane_bits[0]);
    end
  end

endmodule

// File: rtl/rj_audio_rx_chk.sv
module rj_audio_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        active,
  input logic        armed,
  input logic        dual_mode,
  input logic [2:0]  fmt_code,
  input logic        valid_l,
  input logic        valid_r,
  input logic [31:0] word_l,
  input logic [31:0] word_r,
  input logic        locked
);

  a_r1_fmt_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_code inside {3'b000, 3'b001, 3'b010});

  a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !(valid_l || valid_r));

  a_r10_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !locked);

  a_r7_dual_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dual_mode) |=> (valid_l == valid_r));

  a_r6_single_split: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dual_mode) |=> !(valid_l && valid_r));

  a_r8_armed_first: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_l || valid_r) |-> $past(armed));

  a_r9_pulse_l: assert property (@(posedge clk) disable iff (!rst_n)
    valid_l |=> !valid_l);

  a_r9_pulse_r: assert property (@(posedge clk) disable iff (!rst_n)
    valid_r |=> !valid_r);

  a_r9_hold_l: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_l |-> $stable(word_l));

  a_r9_hold_r: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_r |-> $stable(word_r));

endmodule

bind rj_audio_rx rj_audio_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (active),
  .armed     (armed),
  .dual_mode (dual_mode),
  .fmt_code  (fmt_code),
  .valid_l   (valid_l),
  .valid_r   (valid_r),
  .word_l    (word_l),
  .word_r    (word_r),
  .locked    (locked)
);

// File: tb/rj_audio_rx_tb.sv
module rj_audio_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 32;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_fmt = 3'b000;
  logic        cfg_dual = 1'b0, cfg_dsd_sel = 1'b0, cfg_thru = 1'b0;
  logic        bck = 1'b0, wck = 1'b0;
  logic        sdata = 1'b0, sdata_l = 1'b0, sdata_r = 1'b0;
  logic [31:0] word_l, word_r;
  logic        valid_l, valid_r, locked;

  always #(CLK_PERIOD/2) clk = ~clk;

  rj_audio_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt),
    .cfg_dual(cfg_dual), .cfg_dsd_sel(cfg_dsd_sel), .cfg_thru(cfg_thru),
    .bck(bck), .wck(wck), .sdata(sdata), .sdata_l(sdata_l), .sdata_r(sdata_r),
    .word_l(word_l), .word_r(word_r), .valid_l(valid_l), .valid_r(valid_r),
    .locked(locked)
  );

  int          checks = 0, fails = 0;
  int          seen_l = 0, seen_r = 0;
  string       run_tag = "R8";
  logic [31:0] exp_l[$], exp_r[$];
  logic        pv_l = 1'b0, pv_r = 1'b0;
  logic [31:0] pw_l = '0, pw_r = '0, held_l = '0, held_r = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Arithmetic sign extension of an n-bit value (R5).
  function automatic logic [31:0] ext(input int n, input logic [31:0] v);
    if (n == 32) return v;
    if (v[n-1]) return v | ~((32'd1 << n) - 32'd1);
    return v;
  endfunction

  function automatic logic [31:0] mask_of(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] pick(input int n, input int k);
    case (k % 4)
      1:       return 32'd1 << (n - 1);
      2:       return mask_of(n) >> 1;
      3:       return mask_of(n);
      default: return $urandom() & mask_of(n);
    endcase
  endfunction

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_l) begin
        seen_l++;
        check(!pv_l && pw_l == held_l, "R9", "left strobe/hold", pw_l, held_l);
        if (exp_l.size() == 0) check(1'b0, run_tag, "unexpected left word", word_l, '0);
        else begin
          logic [31:0] e;
          e = exp_l.pop_front();
          check(word_l == e, run_tag, "left word", word_l, e);
        end
        held_l = word_l;
      end
      if (valid_r) begin
        seen_r++;
        check(!pv_r && pw_r == held_r, "R9", "right strobe/hold", pw_r, held_r);
        if (exp_r.size() == 0) check(1'b0, run_tag, "unexpected right word", word_r, '0);
        else begin
          logic [31:0] e;
          e = exp_r.pop_front();
          check(word_r == e, run_tag, "right word", word_r, e);
        end
        held_r = word_r;
      end
    end
    pv_l = valid_l; pv_r = valid_r; pw_l = word_l; pw_r = word_r;
  end

  task automatic cfg_write(input logic [2:0] f, input logic d, input logic ds, input logic th);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_fmt = f; cfg_dual = d; cfg_dsd_sel = ds; cfg_thru = th;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic bit_cycle(input logic w, input logic d, input logic dl, input logic dr);
    @(negedge clk);
    bck = 1'b0; wck = w; sdata = d; sdata_l = dl; sdata_r = dr;
    @(negedge clk);
    @(negedge clk);
    bck = 1'b1;
    @(negedge clk);
  endtask

  task automatic single_run(input int n, input int frames, input bit expect_out);
    for (int f = 0; f < frames; f++) begin
      logic [31:0] lw, rw;
      lw = pick(n, f);
      rw = pick(n, f + 2);
      if (expect_out) begin
        if (f > 0) exp_l.push_back(ext(n, lw));   // R8: first fall only arms
        exp_r.push_back(ext(n, rw));
      end
      for (int i = 0; i < HALF; i++)
        bit_cycle(1'b1, (i < HALF - n) ? 1'($urandom()) : lw[HALF-1-i],
                  1'($urandom()), 1'($urandom()));
      for (int i = 0; i < HALF; i++)
        bit_cycle(1'b0, (i < HALF - n) ? 1'($urandom()) : rw[HALF-1-i],
                  1'($urandom()), 1'($urandom()));
    end
    bit_cycle(1'b1, 1'b0, 1'b0, 1'b0);
    bit_cycle(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic dual_frame(input int n, input int len, input bit push);
    logic [31:0] lw, rw;
    lw = pick(n, $urandom_range(0, 3));
    rw = pick(n, $urandom_range(0, 3));
    if (push) begin
      exp_l.push_back(ext(n, lw));
      exp_r.push_back(ext(n, rw));
    end
    for (int i = 0; i < len; i++)
      bit_cycle((i < len / 2) ? 1'b0 : 1'b1, 1'($urandom()),
                (i < len - n) ? 1'($urandom()) : lw[len-1-i],
                (i < len - n) ? 1'($urandom()) : rw[len-1-i]);
  endtask

  task automatic dual_run(input int n, input int frames);
    for (int f = 0; f < frames; f++) dual_frame(n, 2 * HALF, f > 0);
    bit_cycle(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run(input string tag, input logic [2:0] f);
    repeat (4) @(negedge clk);
    check(locked == 1'b1, "R10", "locked after steady frames", 32'(locked), 32'd1);
    check(exp_l.size() == 0 && exp_r.size() == 0, tag, "words outstanding",
          32'(exp_l.size() + exp_r.size()), 32'd0);
    cfg_write(f, 1'b0, 1'b0, 1'b0);
    wck = 1'b0;
    repeat (2) @(negedge clk);
    check(locked == 1'b0, "R10", "lock cleared when idle", 32'(locked), 32'd0);
  endtask

  initial begin : watchdog
    repeat (WD_LIMIT) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog expired: actual %0d cycles expected completion", WD_LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!valid_l && !valid_r, "R9", "reset strobes", {30'd0, valid_l, valid_r}, '0);
    check(word_l == '0 && word_r == '0, "R9", "reset words", word_l | word_r, '0);
    check(locked == 1'b0, "R10", "reset lock", 32'(locked), '0);

    // R1 default 24-bit kept, R2 illegal code ignored while mode bits apply.
    run_tag = "R1 R2 R4 R5 R6 R8";
    cfg_write(3'b111, 1'b0, 1'b0, 1'b1);
    single_run(24, 4, 1'b1);
    finish_run(run_tag, 3'b010);

    run_tag = "R1 R4 R5 R6";
    cfg_write(3'b000, 1'b0, 1'b0, 1'b1);
    single_run(16, 4, 1'b1);
    finish_run(run_tag, 3'b000);

    cfg_write(3'b001, 1'b0, 1'b0, 1'b1);
    single_run(32, 4, 1'b1);
    finish_run(run_tag, 3'b001);

    run_tag = "R7 R4 R5 R8";
    cfg_write(3'b000, 1'b1, 1'b0, 1'b1);
    dual_run(16, 4);
    finish_run(run_tag, 3'b000);

    cfg_write(3'b010, 1'b1, 1'b0, 1'b1);
    dual_run(24, 4);
    finish_run(run_tag, 3'b010);

    cfg_write(3'b001, 1'b1, 1'b0, 1'b1);
    dual_run(32, 4);
    finish_run(run_tag, 3'b001);

    // R2: illegal code after 16-bit setting keeps 16 bits, dual bit applies.
    run_tag = "R2 R7";
    cfg_write(3'b000, 1'b0, 1'b0, 1'b0);
    cfg_write(3'b110, 1'b1, 1'b0, 1'b1);
    dual_run(16, 4);
    finish_run(run_tag, 3'b000);

    // R10: period length change drops and then regains lock.
    run_tag = "R10 R7";
    cfg_write(3'b000, 1'b1, 1'b0, 1'b1);
    dual_frame(16, 64, 1'b0);
    dual_frame(16, 64, 1'b1);
    dual_frame(16, 64, 1'b1);
    dual_frame(16, 60, 1'b1);
    check(locked == 1'b1, "R10", "lock on equal periods", 32'(locked), 32'd1);
    dual_frame(16, 60, 1'b1);
    check(locked == 1'b0, "R10", "lock lost on changed period", 32'(locked), 32'd0);
    bit_cycle(1'b0, 1'b0, 1'b0, 1'b0);
    finish_run(run_tag, 3'b000);

    // R3: stream select set, then pass-through clear; nothing delivered.
    run_tag = "R3";
    for (int m = 0; m < 2; m++) begin
      int sl, sr;
      sl = seen_l; sr = seen_r;
      cfg_write(3'b000, 1'b0, (m == 0), (m == 0));
      single_run(16, 3, 1'b0);
      repeat (4) @(negedge clk);
      check(seen_l == sl && seen_r == sr, "R3", "strobes while idle",
            32'(seen_l + seen_r - sl - sr), 32'd0);
      check(locked == 1'b0, "R3", "lock while idle", 32'(locked), 32'd0);
      cfg_write(3'b000, 1'b0, 1'b0, 1'b0);
      wck = 1'b0;
      repeat (2) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule